// File: doc/BRIEF.md
# Terminal Address Latch and Validation

This block holds the terminal's own 5-bit address and its parity bit, taken from external pins, and decides whether each decoded command word is addressed to the terminal. A hold input controls a level-sensitive latch. While hold is low, the pins pass straight through. Once hold has been seen high at a clock edge, the address and parity stay frozen at the values sampled at that edge.

The six held bits must contain an odd number of ones. If they do not, an active-low error flag is driven. A parity failure stops the terminal from answering or taking data on any non-broadcast command. Broadcast commands (address field all ones) are still accepted, and they never request a status reply.

Each decoded command word arrives with a one-cycle valid strobe. One clock later the block produces the following:
- an accept pulse,
- a status-reply request,
- a broadcast flag,
- the transmit/receive bit, the subaddress and the word count, all taken from that command.

Top module: `term_addr_check`

## Requirements
- R1: While `addr_hold` is low, the effective address and parity equal `addr_pins`/`addr_par` in the same cycle, with no clock delay. This is visible through `addr_err_n` and through the accept decision.
- R2: At the first rising clock edge where `addr_hold` is high, the effective address and parity are captured from the pins. While `addr_hold` stays high, pin changes have no effect on them.
- R3: `addr_err_n` is low exactly when the five effective address bits together with the effective parity bit hold an even number of ones.
- R4: Command word fields are laid out as follows:
  - bits [15:11]: target address
  - bit [10]: transmit/receive
  - bits [9:5]: subaddress
  - bits [4:0]: word count/mode code
  A target address of 31 marks a broadcast.
- R5: A strobed command meets all three conditions: its target equals the effective address, that address is not 31, and parity is good. Such a command gives `resp_acc`=1, `resp_stat`=1 and `resp_bcast`=0 one clock later.
- R6: When parity is bad, a non-broadcast command gives `resp_acc`=0 and `resp_stat`=0, whatever its target address.
- R7: A broadcast command gives `resp_acc`=1, `resp_bcast`=1 and `resp_stat`=0 one clock later, whether parity is good or bad.
- R8: A non-broadcast command whose target differs from the effective address gives `resp_acc`=0 and `resp_stat`=0.
- R9: The outputs `resp_acc`, `resp_stat` and `resp_bcast` are 1 only in the cycle after a strobe. On each strobe, `resp_tr`, `resp_sub` and `resp_cnt` load that command's fields and then keep them until the next strobe.
- R10: After reset, all `resp_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_pins | input | 5 | Terminal address pins |
| addr_par | input | 1 | Address parity pin |
| addr_hold | input | 1 | Latch control: low = transparent, high = frozen |
| cmd_word | input | 16 | Decoded command word |
| cmd_valid | input | 1 | One-cycle strobe for cmd_word |
| addr_err_n | output | 1 | Low when address parity is even |
| resp_acc | output | 1 | Command accepted |
| resp_stat | output | 1 | Status reply requested |
| resp_bcast | output | 1 | Command was broadcast |
| resp_tr | output | 1 | Transmit/receive bit of the command |
| resp_sub | output | 5 | Subaddress of the command |
| resp_cnt | output | 5 | Word count/mode code of the command |

## Verification
If the held address is wrong, the next command sent to the true address comes back rejected, and a command to the stale address is accepted instead. Both show one clock after the strobe. A wrong held parity bit flips `addr_err_n` at once, with no clock needed. A freeze taken at the wrong edge shows up as a changed accept decision as soon as the pins move while hold is high. Random commands aimed mostly at the current address and at 31, mixed with hold toggling, expose each of these within a few cycles.

// File: rtl/term_addr_check.sv
module term_addr_check #(
  parameter int AW   = 5,
  parameter int SA_W = 5,
  parameter int WC_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               addr_pins,
  input  logic                        addr_par,
  input  logic                        addr_hold,
  input  logic [AW+1+SA_W+WC_W-1:0]   cmd_word,
  input  logic                        cmd_valid,
  output logic                        addr_err_n,
  output logic                        resp_acc,
  output logic                        resp_stat,
  output logic                        resp_bcast,
  output logic                        resp_tr,
  output logic [SA_W-1:0]             resp_sub,
  output logic [WC_W-1:0]             resp_cnt
);
  localparam int CW = AW + 1 + SA_W + WC_W;
  localparam logic [AW-1:0] BCAST = '1;

  logic          frozen;
  logic [AW-1:0] held_addr;
  logic          held_par;
  logic [AW-1:0] eff_addr;
  logic          eff_par;
  logic [AW-1:0] tgt;
  logic          par_ok, is_bc, is_own, acc_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frozen    <= 1'b0;
      held_addr <= '0;
      held_par  <= 1'b0;
    end else begin
      frozen <= addr_hold;
      if (!frozen) begin
        held_addr <= addr_pins;
        held_par  <= addr_par;
      end
    end

  assign eff_addr   = (addr_hold && frozen) ? held_addr : addr_pins;
  assign eff_par    = (addr_hold && frozen) ? held_par  : addr_par;
  assign par_ok     = ^{eff_addr, eff_par};
  assign addr_err_n = par_ok;

  assign tgt    = cmd_word[CW-1 -: AW];
  assign is_bc  = (tgt == BCAST);
  assign is_own = (tgt == eff_addr) && !is_bc;
  assign acc_d  = is_bc || (is_own && par_ok);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resp_acc   <= 1'b0;
      resp_stat  <= 1'b0;
      resp_bcast <= 1'b0;
      resp_tr    <= 1'b0;
      resp_sub   <= '0;
      resp_cnt   <= '0;
    end else begin
      resp_acc   <= cmd_valid && acc_d;
      resp_stat  <= cmd_valid && is_own && par_ok;
      resp_bcast <= cmd_valid && is_bc;
      if (cmd_valid) begin
        resp_tr  <= cmd_word[SA_W+WC_W];
        resp_sub <= cmd_word[SA_W+WC_W-1 -: SA_W];
        resp_cnt <= cmd_word[WC_W-1:0];
      end
    end

  AST_STAT_IMPLIES_ACC: assert property (@(posedge clk) disable iff (!rst_n) resp_stat |-> resp_acc); // R5
  AST_BCAST_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n) resp_bcast |-> (resp_acc && !resp_stat)); // R7
  AST_PARERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !addr_err_n && tgt != BCAST) |=> (!resp_acc && !resp_stat)); // R6
  AST_OWN_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && addr_err_n && tgt == eff_addr && tgt != BCAST) |=> (resp_acc && resp_stat)); // R5
  AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!resp_acc && !resp_bcast && !resp_stat)); // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(resp_sub) && $stable(resp_cnt) && $stable(resp_tr))); // R9
endmodule

// File: tb/term_addr_check_test.sv
`timescale 1ns/1ps
module term_addr_check_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] addr_pins = 0;
  logic addr_par = 0, addr_hold = 0, cmd_valid = 0;
  logic [15:0] cmd_word = 0;
  logic addr_err_n, resp_acc, resp_stat, resp_bcast, resp_tr;
  logic [4:0] resp_sub, resp_cnt;
  int checks = 0, errors = 0;
  logic m_frozen = 0, m_par = 0;
  logic [4:0] m_addr = 0;
  logic [15:0] last_cmd = 0;

  always #2.5 clk = ~clk;

  term_addr_check uut (.*);

  function automatic logic [4:0] eff_a();
    return (addr_hold && m_frozen) ? m_addr : addr_pins;
  endfunction
  function automatic logic eff_p();
    return (addr_hold && m_frozen) ? m_par : addr_par;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [4:0] pins, logic par, logic hold, logic v, logic [15:0] cw);
    logic ea_ok, e_acc, e_stat, e_bc;
    logic [4:0] ea;
    @(negedge clk);
    addr_pins = pins; addr_par = par; addr_hold = hold; cmd_valid = v; cmd_word = cw;
    #0.5;
    ea = eff_a();
    ea_ok = ^{ea, eff_p()};
    chk(hold ? "R2" : "R1", addr_err_n, ea_ok, "addr_err_n (R3)");
    e_bc   = v && cw[15:11] == 5'd31;
    e_stat = v && !e_bc && cw[15:11] == ea && ea_ok;
    e_acc  = e_bc || e_stat;
    if (v) last_cmd = cw;
    @(posedge clk);
    if (!m_frozen) begin m_addr = pins; m_par = par; end
    m_frozen = hold;
    #1;
    chk(e_bc ? "R7" : (!ea_ok ? "R6" : (e_stat ? "R5" : "R8")), resp_acc, e_acc, "resp_acc");
    chk(e_bc ? "R7" : "R5", resp_stat, e_stat, "resp_stat");
    chk("R4", resp_bcast, e_bc, "resp_bcast");
    chk("R9", {resp_tr, resp_sub, resp_cnt}, last_cmd[10:0], "fields");
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] a;
    void'($urandom(32'd1553));
    #12;
    chk("R10", {resp_acc, resp_stat, resp_bcast, resp_tr, resp_sub, resp_cnt}, 0, "reset outputs");
    rst_n = 1;
    // directed: good parity own address (5 = 00101 has 2 ones -> par 1)
    step(5'd5, 1, 0, 1, {5'd5, 1'b1, 5'd3, 5'd7});          // R5
    step(5'd5, 0, 0, 1, {5'd5, 1'b0, 5'd3, 5'd7});          // R6
    step(5'd5, 0, 0, 1, {5'd31, 1'b0, 5'd9, 5'd2});         // R7 with bad parity
    step(5'd5, 1, 0, 1, {5'd6, 1'b0, 5'd9, 5'd2});          // R8
    step(5'd5, 1, 0, 0, 16'hFFFF);                          // R9 no strobe
    // R2: freeze at 5, then pins move
    step(5'd5, 1, 1, 0, 0);
    step(5'd9, 0, 1, 1, {5'd5, 1'b1, 5'd1, 5'd1});          // R2 still answers 5
    step(5'd9, 0, 1, 1, {5'd9, 1'b1, 5'd1, 5'd1});          // R2 ignores pins
    step(5'd9, 1, 0, 1, {5'd9, 1'b1, 5'd2, 5'd4});          // R1 transparent again
    // address 31 on pins: broadcast wins, no status
    step(5'd31, 0, 0, 1, {5'd31, 1'b1, 5'd0, 5'd0});        // R7
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] p; logic pr, h, v; logic [15:0] cw; int sel;
      p  = ($urandom % 4 == 0) ? $urandom : addr_pins;
      pr = ($urandom % 5 == 0) ? ~^p : ^~p ^ 1'b0;
      pr = ($urandom % 5 == 0) ? pr : ~(^p);
      h  = ($urandom % 3 == 0) ? ~addr_hold : addr_hold;
      v  = $urandom % 3 != 0;
      cw = $urandom;
      sel = $urandom % 10;
      a = (h && m_frozen) ? m_addr : p;
      if (sel < 5) cw[15:11] = a; else if (sel < 7) cw[15:11] = 5'd31;
      step(p, pr, h, v, cw);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule